// File: doc/BRIEF.md
# Line-Doubled Video Fetch Scheduler

This block produces the raster timing for an 800x600 display driven from a 40 MHz pixel clock. It shows a 400x300 frame held in shared SRAM, one byte per pixel, with each stored pixel repeated across two screen pixels and each stored row repeated across two screen lines. Every scan line is also a fixed schedule of SRAM ownership. The scheduler owns the memory from the start of each line. It first reads one sample for each audio voice. On even display lines it then streams the whole row of the live frame page into an internal line buffer. After that it hands the SRAM to the other requesters by raising a grant flag, which stays high until the line wraps.

Two frame pages share the SRAM. A flip request is held until the frame enters vertical sync, and only then are the live page (shown) and the draw page swapped, so a page never changes in the middle of a frame. The pixel bytes pass through a 256-entry palette with 4 bits per colour. A host port writes that palette one entry per cycle.

Top module: `video_fetch_sched`

## Requirements
- R1: A horizontal count runs from 0 to 1055 and wraps to 0. Each wrap advances a line count that runs from 0 to 627 and wraps to 0. After reset both counts are 0.
- R2: `hsync_n` is low exactly one cycle after each cycle whose horizontal count lies in 928..1055. `vsync_n` is low one cycle after each cycle whose line count lies in 601..604. Both are high during reset.
- R3: On an even line below 600, the count 19+k (k = 0..399) drives `mem_addr` = base + (line/2)*400 + k, where base is 65536 for page 0 and 185536 for page 1 (the live page). The byte returned on `mem_rd_data` in that same cycle is stored as line-buffer entry k.
- R4: Colour outputs are registered. The cycle after horizontal count 88+j (j = 0..799) of a line below 600 shows the palette colour of line-buffer entry j/2, and odd lines repeat the row fetched on the preceding even line. In every other case the outputs are 0 (black).
- R5: A palette entry is 12 bits: red in bits 3:0, green in bits 7:4, blue in bits 11:8. After reset, entry i holds red = i[3:0], green = i[7:4] and blue = i[3:0] xor i[7:4].
- R6: A palette write (`pal_we` high with `pal_idx`, `pal_wdata`) updates only that entry at the clock edge. A pixel registered at that same edge still uses the old colour, and from the next edge on the new colour is used.
- R7: `mem_grant` is low at horizontal count 0. It rises at count 419 on even lines and at count 19 on odd lines, and stays high to the end of the line.
- R8: At horizontal counts 11..18 of every line, `aud_valid` is high, `aud_voice` = count - 11, `mem_addr` carries that voice's slice of `aud_addr` (voice n in bits n*20 .. n*20+19), and `aud_data` returns `mem_rd_data`. `aud_valid` is low at all other counts.
- R9: While `mem_grant` is low, the scheduler alone drives `mem_addr` (never `host_addr` outside a fetch or audio slot) and holds `mem_we_n` high. While it is high, `mem_addr` follows `host_addr` and `mem_we_n` follows `host_we_n`.
- R10: A `flip_req` sampled high is held pending. The live page toggles only at the edge that enters line 601 at count 0, and only if the request was already pending before that edge. A request sampled at that same edge waits for the next frame. `live_page` reports the live page (0 after reset).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| flip_req | input | 1 | Request to swap live and draw pages at next vertical sync |
| host_addr | input | ADDR_W | SRAM address from the granted requester |
| host_we_n | input | 1 | Active-low write enable from the granted requester |
| mem_rd_data | input | 8 | Data returned by SRAM for the current `mem_addr` |
| aud_addr | input | VOICES*ADDR_W | Next sample address of each audio voice |
| pal_we | input | 1 | Palette write strobe |
| pal_idx | input | PIX_W | Palette entry to write |
| pal_wdata | input | 12 | Colour to write: blue 11:8, green 7:4, red 3:0 |
| mem_addr | output | ADDR_W | SRAM address |
| mem_we_n | output | 1 | Active-low SRAM write enable |
| mem_grant | output | 1 | SRAM available to other requesters |
| aud_valid | output | 1 | An audio sample slot is active |
| aud_voice | output | VCW | Voice served in the current slot |
| aud_data | output | 8 | Sample byte for that voice |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| red | output | 4 | Red intensity |
| green | output | 4 | Green intensity |
| blue | output | 4 | Blue intensity |
| live_page | output | 1 | Page currently shown |

## Verification
The bench runs a shrunken raster of 44 by 10 counts over four frames and compares every output in every cycle against an arithmetic model. Three boundaries get the most attention.

The first is the edge between the burst and the grant, and between the audio slots and the grant on odd lines. A grant raised one count early would hand the bus to the host during a fetch, and the address check would show the host address where a row address was expected.

The second is the horizontal and vertical doubling. An off-by-one in the halving would show the wrong palette colour on every second pixel, or would fetch on odd lines. The third is the page swap. A flip request is placed exactly on the vertical-sync entry edge, so a design that acts on it at once would swap one frame early. A design that swaps outside vertical sync would show a different fetch base in the middle of a frame.

// File: rtl/vfs_pkg.sv
package vfs_pkg;

   typedef struct packed {
      logic [3:0] blu;
      logic [3:0] grn;
      logic [3:0] red;
   } rgb12_t;

   // Power-up colour of palette entry idx.
   function automatic rgb12_t pal_seed(input int unsigned idx);
      logic [7:0] b;
      rgb12_t     c;
      b     = idx[7:0];
      c.red = b[3:0];
      c.grn = b[7:4];
      c.blu = b[3:0] ^ b[7:4];
      return c;
   endfunction

endpackage

// File: rtl/vfs_timing.sv
module vfs_timing #(
   parameter int H_TOTAL  = 1056,
   parameter int V_TOTAL  = 628,
   parameter int HS_START = 928,
   parameter int VS_FIRST = 601,
   parameter int VS_LAST  = 604,
   parameter int HW       = $clog2(H_TOTAL),
   parameter int VW       = $clog2(V_TOTAL)
) (
   input  logic          clk,
   input  logic          rst_n,
   output logic [HW-1:0] h,
   output logic [VW-1:0] v,
   output logic          hsync_n,
   output logic          vsync_n,
   output logic          vs_entry
);

   localparam logic [HW-1:0] H_LAST_H  = HW'(H_TOTAL - 1);
   localparam logic [VW-1:0] V_LAST_V  = VW'(V_TOTAL - 1);
   localparam logic [HW-1:0] HS_H      = HW'(HS_START);
   localparam logic [VW-1:0] VSF_V     = VW'(VS_FIRST);
   localparam logic [VW-1:0] VSL_V     = VW'(VS_LAST);
   localparam logic [VW-1:0] VS_PRE_V  = VW'(VS_FIRST - 1);

   if (HS_START >= H_TOTAL) begin : g_bad_hs
      $error("hsync start outside line");
   end
   if (VS_FIRST < 1 || VS_LAST < VS_FIRST || VS_LAST >= V_TOTAL) begin : g_bad_vs
      $error("vsync window outside frame");
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         h       <= '0;
         v       <= '0;
         hsync_n <= 1'b1;
         vsync_n <= 1'b1;
      end else begin
         if (h == H_LAST_H) begin
            h <= '0;
            v <= (v == V_LAST_V) ? '0 : v + 1'b1;
         end else begin
            h <= h + 1'b1;
         end
         hsync_n <= !(h >= HS_H);
         vsync_n <= !((v >= VSF_V) && (v <= VSL_V));
      end
   end

   assign vs_entry = (h == H_LAST_H) && (v == VS_PRE_V);

   a_r1_h_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (h == H_LAST_H) |=> (h == '0));
   a_r1_v_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (h != H_LAST_H) |=> $stable(v));
   a_r2_hsync_late: assert property (@(posedge clk) disable iff (!rst_n)
      (h == HS_H) |=> !hsync_n);

endmodule

// File: rtl/vfs_fetch.sv
module vfs_fetch #(
   parameter int H_TOTAL    = 1056,
   parameter int V_TOTAL    = 628,
   parameter int V_ACTIVE   = 600,
   parameter int VS_FIRST   = 601,
   parameter int ROW_PIX    = 400,
   parameter int FETCH_AT   = 18,
   parameter int VOICES     = 8,
   parameter int ADDR_W     = 20,
   parameter int PAGE0_BASE = 65536,
   parameter int HW         = $clog2(H_TOTAL),
   parameter int VW         = $clog2(V_TOTAL),
   parameter int LBW        = (ROW_PIX > 1) ? $clog2(ROW_PIX) : 1,
   parameter int VCW        = (VOICES > 1) ? $clog2(VOICES) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic [HW-1:0]            h,
   input  logic [VW-1:0]            v,
   input  logic                     vs_entry,
   input  logic                     flip_req,
   input  logic [ADDR_W-1:0]        host_addr,
   input  logic                     host_we_n,
   input  logic [7:0]               mem_rd_data,
   input  logic [VOICES*ADDR_W-1:0] aud_addr,
   input  logic [LBW-1:0]           lb_rd_idx,
   output logic [7:0]               lb_rd_data,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic                     mem_we_n,
   output logic                     mem_grant,
   output logic                     aud_valid,
   output logic [VCW-1:0]           aud_voice,
   output logic [7:0]               aud_data,
   output logic                     live_page
);

   localparam int AUD_FIRST   = FETCH_AT - VOICES + 1;
   localparam int BURST_FIRST = FETCH_AT + 1;
   localparam int BURST_LAST  = FETCH_AT + ROW_PIX;
   localparam int PAGE_BYTES  = ROW_PIX * (V_ACTIVE / 2);
   localparam int PAGE1_BASE  = PAGE0_BASE + PAGE_BYTES;

   localparam logic [HW-1:0] AUD_FIRST_H   = HW'(AUD_FIRST);
   localparam logic [HW-1:0] FETCH_H       = HW'(FETCH_AT);
   localparam logic [HW-1:0] BURST_FIRST_H = HW'(BURST_FIRST);
   localparam logic [HW-1:0] BURST_LAST_H  = HW'(BURST_LAST);
   localparam logic [HW-1:0] EVEN_GNT_H    = HW'(BURST_LAST + 1);
   localparam logic [HW-1:0] ODD_GNT_H     = HW'(BURST_FIRST);
   localparam logic [VW-1:0] VACT_V        = VW'(V_ACTIVE);
   localparam logic [VW-1:0] VSF_V         = VW'(VS_FIRST);
   localparam logic [ADDR_W-1:0] PAGE0_A   = ADDR_W'(PAGE0_BASE);
   localparam logic [ADDR_W-1:0] PAGE1_A   = ADDR_W'(PAGE1_BASE);
   localparam logic [ADDR_W-1:0] ROW_A     = ADDR_W'(ROW_PIX);

   if (AUD_FIRST < 1) begin : g_bad_aud
      $error("audio slots do not fit before the fetch load");
   end
   if (BURST_LAST + 1 >= H_TOTAL) begin : g_bad_burst
      $error("burst does not fit in a line");
   end
   if (longint'(PAGE1_BASE) + PAGE_BYTES > (longint'(1) << ADDR_W)) begin : g_bad_page
      $error("frame pages exceed address space");
   end
   if (V_ACTIVE % 2 != 0) begin : g_bad_vact
      $error("active line count must be even for line doubling");
   end

   // ---------------- slot decode ----------------
   logic fetch_line, in_aud, in_burst, load_row;
   assign fetch_line = !v[0] && (v < VACT_V);
   assign in_aud     = (h >= AUD_FIRST_H) && (h <= FETCH_H);
   assign in_burst   = fetch_line && (h >= BURST_FIRST_H) && (h <= BURST_LAST_H);
   assign load_row   = fetch_line && (h == FETCH_H);
   assign mem_grant  = v[0] ? (h >= ODD_GNT_H) : (h >= EVEN_GNT_H);

   // ---------------- page select ----------------
   logic flip_pend;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         live_page <= 1'b0;
         flip_pend <= 1'b0;
      end else if (vs_entry && flip_pend) begin
         live_page <= !live_page;
         flip_pend <= flip_req;
      end else begin
         flip_pend <= flip_pend | flip_req;
      end
   end

   // ---------------- fetch pointer ----------------
   logic [ADDR_W-1:0] page_base, row_base, fetch_ptr;
   assign page_base = live_page ? PAGE1_A : PAGE0_A;
   assign row_base  = page_base + ADDR_W'(v[VW-1:1]) * ROW_A;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fetch_ptr <= '0;
      end else if (load_row) begin
         fetch_ptr <= row_base;
      end else if (in_burst) begin
         fetch_ptr <= fetch_ptr + 1'b1;
      end
   end

   // ---------------- line buffer ----------------
   logic [7:0]     lbuf [ROW_PIX];
   logic [LBW-1:0] wr_idx;
   assign wr_idx = LBW'(int'(h) - BURST_FIRST);

   always_ff @(posedge clk) begin
      if (in_burst) begin
         lbuf[wr_idx] <= mem_rd_data;
      end
   end
   assign lb_rd_data = lbuf[lb_rd_idx];

   // ---------------- audio voice select ----------------
   if (VOICES > 1) begin : g_multi_voice
      assign aud_voice = VCW'(int'(h) - AUD_FIRST);
   end else begin : g_single_voice
      assign aud_voice = '0;
   end

   logic [ADDR_W-1:0] voice_addr;
   assign voice_addr = aud_addr[int'(aud_voice)*ADDR_W +: ADDR_W];
   assign aud_valid  = in_aud;
   assign aud_data   = mem_rd_data;

   // ---------------- SRAM ownership ----------------
   always_comb begin
      if (in_aud) begin
         mem_addr = voice_addr;
      end else if (mem_grant) begin
         mem_addr = host_addr;
      end else begin
         mem_addr = fetch_ptr;
      end
   end
   assign mem_we_n = mem_grant ? host_we_n : 1'b1;

   a_r7_grant_drop: assert property (@(posedge clk) disable iff (!rst_n)
      (h == '0) |-> !mem_grant);
   a_r9_we_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_grant |-> mem_we_n);
   a_r8_aud_blackout: assert property (@(posedge clk) disable iff (!rst_n)
      aud_valid |-> !mem_grant);
   a_r3_burst_step: assert property (@(posedge clk) disable iff (!rst_n)
      (in_burst && (h != BURST_FIRST_H)) |-> (mem_addr == $past(mem_addr) + 1'b1));
   a_r10_swap_vsync: assert property (@(posedge clk) disable iff (!rst_n)
      (live_page != $past(live_page)) |-> ((v == VSF_V) && (h == '0)));

endmodule

// File: rtl/vfs_palette.sv
module vfs_palette
   import vfs_pkg::*;
#(
   parameter int PIX_W   = 8,
   parameter int ENTRIES = 2 ** PIX_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pal_we,
   input  logic [PIX_W-1:0] pal_idx,
   input  logic [11:0]      pal_wdata,
   input  logic [PIX_W-1:0] pix_idx,
   input  logic             disp_en,
   output logic [3:0]       red,
   output logic [3:0]       green,
   output logic [3:0]       blue
);

   if (ENTRIES != 2 ** PIX_W) begin : g_bad_entries
      $error("palette depth must match pixel width");
   end

   rgb12_t tbl [ENTRIES];

   for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
      rgb12_t ent_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            ent_q <= pal_seed(i);
         end else if (pal_we && (pal_idx == PIX_W'(i))) begin
            ent_q <= rgb12_t'(pal_wdata);
         end
      end
      assign tbl[i] = ent_q;
   end

   rgb12_t out_q;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_q <= '0;
      end else begin
         out_q <= disp_en ? tbl[pix_idx] : '0;
      end
   end

   assign red   = out_q.red;
   assign green = out_q.grn;
   assign blue  = out_q.blu;

   a_r4_blank: assert property (@(posedge clk) disable iff (!rst_n)
      !disp_en |=> (out_q == '0));
   a_r6_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      pal_we |=> (tbl[$past(pal_idx)] == rgb12_t'($past(pal_wdata))));

endmodule

// File: rtl/video_fetch_sched.sv
module video_fetch_sched #(
   parameter int H_TOTAL    = 1056,
   parameter int HS_START   = 928,
   parameter int V_TOTAL    = 628,
   parameter int V_ACTIVE   = 600,
   parameter int VS_FIRST   = 601,
   parameter int VS_LAST    = 604,
   parameter int ROW_PIX    = 400,
   parameter int FETCH_AT   = 18,
   parameter int PIX_START  = 88,
   parameter int VOICES     = 8,
   parameter int ADDR_W     = 20,
   parameter int PAGE0_BASE = 65536,
   parameter int PIX_W      = 8,
   parameter int VCW        = (VOICES > 1) ? $clog2(VOICES) : 1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     flip_req,
   input  logic [ADDR_W-1:0]        host_addr,
   input  logic                     host_we_n,
   input  logic [7:0]               mem_rd_data,
   input  logic [VOICES*ADDR_W-1:0] aud_addr,
   input  logic                     pal_we,
   input  logic [PIX_W-1:0]         pal_idx,
   input  logic [11:0]              pal_wdata,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic                     mem_we_n,
   output logic                     mem_grant,
   output logic                     aud_valid,
   output logic [VCW-1:0]           aud_voice,
   output logic [7:0]               aud_data,
   output logic                     hsync_n,
   output logic                     vsync_n,
   output logic [3:0]               red,
   output logic [3:0]               green,
   output logic [3:0]               blue,
   output logic                     live_page
);

   localparam int HW       = $clog2(H_TOTAL);
   localparam int VW       = $clog2(V_TOTAL);
   localparam int LBW      = (ROW_PIX > 1) ? $clog2(ROW_PIX) : 1;
   localparam int PIX_LAST = PIX_START + 2 * ROW_PIX - 1;

   localparam logic [HW-1:0] PIX_FIRST_H = HW'(PIX_START);
   localparam logic [HW-1:0] PIX_LAST_H  = HW'(PIX_LAST);
   localparam logic [VW-1:0] VACT_V      = VW'(V_ACTIVE);

   if (PIX_LAST >= HS_START) begin : g_bad_pix
      $error("visible pixels overlap horizontal sync");
   end
   if (FETCH_AT + 1 >= PIX_START) begin : g_bad_order
      $error("line buffer entry would be shown before it is filled");
   end
   if (V_ACTIVE >= VS_FIRST) begin : g_bad_vact
      $error("active lines overlap vertical sync");
   end
   if (PIX_W != 8) begin : g_bad_pixw
      $error("pixels are bytes");
   end

   logic [HW-1:0]  h;
   logic [VW-1:0]  v;
   logic           vs_entry;
   logic           disp_en;
   logic [LBW-1:0] lb_rd_idx;
   logic [7:0]     lb_rd_data;

   vfs_timing #(
      .H_TOTAL (H_TOTAL),
      .V_TOTAL (V_TOTAL),
      .HS_START(HS_START),
      .VS_FIRST(VS_FIRST),
      .VS_LAST (VS_LAST),
      .HW      (HW),
      .VW      (VW)
   ) u_timing (
      .clk     (clk),
      .rst_n   (rst_n),
      .h       (h),
      .v       (v),
      .hsync_n (hsync_n),
      .vsync_n (vsync_n),
      .vs_entry(vs_entry)
   );

   vfs_fetch #(
      .H_TOTAL   (H_TOTAL),
      .V_TOTAL   (V_TOTAL),
      .V_ACTIVE  (V_ACTIVE),
      .VS_FIRST  (VS_FIRST),
      .ROW_PIX   (ROW_PIX),
      .FETCH_AT  (FETCH_AT),
      .VOICES    (VOICES),
      .ADDR_W    (ADDR_W),
      .PAGE0_BASE(PAGE0_BASE),
      .HW        (HW),
      .VW        (VW),
      .LBW       (LBW),
      .VCW       (VCW)
   ) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .h          (h),
      .v          (v),
      .vs_entry   (vs_entry),
      .flip_req   (flip_req),
      .host_addr  (host_addr),
      .host_we_n  (host_we_n),
      .mem_rd_data(mem_rd_data),
      .aud_addr   (aud_addr),
      .lb_rd_idx  (lb_rd_idx),
      .lb_rd_data (lb_rd_data),
      .mem_addr   (mem_addr),
      .mem_we_n   (mem_we_n),
      .mem_grant  (mem_grant),
      .aud_valid  (aud_valid),
      .aud_voice  (aud_voice),
      .aud_data   (aud_data),
      .live_page  (live_page)
   );

   assign disp_en   = (v < VACT_V) && (h >= PIX_FIRST_H) && (h <= PIX_LAST_H);
   assign lb_rd_idx = disp_en ? LBW'((int'(h) - PIX_START) / 2) : '0;

   vfs_palette #(
      .PIX_W(PIX_W)
   ) u_palette (
      .clk      (clk),
      .rst_n    (rst_n),
      .pal_we   (pal_we),
      .pal_idx  (pal_idx),
      .pal_wdata(pal_wdata),
      .pix_idx  (lb_rd_data),
      .disp_en  (disp_en),
      .red      (red),
      .green    (green),
      .blue     (blue)
   );

   a_r9_host_passthru: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_grant && !aud_valid) |-> ((mem_addr == host_addr) && (mem_we_n == host_we_n)));

endmodule

// File: tb/tb_video_fetch_sched.sv
module tb_video_fetch_sched;

   localparam int HT  = 44;
   localparam int HS  = 40;
   localparam int VT  = 10;
   localparam int VA  = 6;
   localparam int VSF = 7;
   localparam int VSL = 8;
   localparam int RP  = 8;
   localparam int FA  = 10;
   localparam int PS  = 20;
   localparam int NV  = 2;
   localparam int AW  = 20;
   localparam int P0  = 64;
   localparam int P1  = P0 + RP * (VA / 2);
   localparam int AUD0 = FA - NV + 1;
   localparam int NCYC = 4 * HT * VT;
   localparam logic [AW-1:0] VADDR0 = 20'h00300;
   localparam logic [AW-1:0] VADDR1 = 20'h00345;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          flip_req;
   logic [AW-1:0] host_addr;
   logic          host_we_n;
   logic [7:0]    mem_rd_data;
   logic [NV*AW-1:0] aud_addr;
   logic          pal_we;
   logic [7:0]    pal_idx;
   logic [11:0]   pal_wdata;
   logic [AW-1:0] mem_addr;
   logic          mem_we_n, mem_grant, aud_valid;
   logic [0:0]    aud_voice;
   logic [7:0]    aud_data;
   logic          hsync_n, vsync_n, live_page;
   logic [3:0]    red, green, blue;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   function automatic logic [7:0] sram(input logic [AW-1:0] a);
      return 8'(int'(a) * 37 + 11);
   endfunction

   always_comb mem_rd_data = sram(mem_addr);

   video_fetch_sched #(
      .H_TOTAL(HT), .HS_START(HS), .V_TOTAL(VT), .V_ACTIVE(VA),
      .VS_FIRST(VSF), .VS_LAST(VSL), .ROW_PIX(RP), .FETCH_AT(FA),
      .PIX_START(PS), .VOICES(NV), .ADDR_W(AW), .PAGE0_BASE(P0), .PIX_W(8)
   ) dut (
      .clk(clk), .rst_n(rst_n), .flip_req(flip_req), .host_addr(host_addr),
      .host_we_n(host_we_n), .mem_rd_data(mem_rd_data), .aud_addr(aud_addr),
      .pal_we(pal_we), .pal_idx(pal_idx), .pal_wdata(pal_wdata),
      .mem_addr(mem_addr), .mem_we_n(mem_we_n), .mem_grant(mem_grant),
      .aud_valid(aud_valid), .aud_voice(aud_voice), .aud_data(aud_data),
      .hsync_n(hsync_n), .vsync_n(vsync_n), .red(red), .green(green),
      .blue(blue), .live_page(live_page)
   );

   logic [11:0] pal_m [256];

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", tag, act, exp);
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL R1 watchdog actual hung expected finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      bit live_m, pend_m, pw_pend, f;
      int pw_idx, pw_data, h, v, hp, vp, nx, exp_rgb, base;
      live_m = 1'b0; pend_m = 1'b0; pw_pend = 1'b0; pw_idx = 0; pw_data = 0;
      // R5 power-up palette contents
      for (int i = 0; i < 256; i++) begin
         logic [7:0] b;
         b = 8'(i);
         pal_m[i] = {b[3:0] ^ b[7:4], b[7:4], b[3:0]};
      end
      rst_n = 1'b0; flip_req = 1'b0; host_addr = 20'h80000; host_we_n = 1'b1;
      aud_addr = {VADDR1, VADDR0}; pal_we = 1'b0; pal_idx = '0; pal_wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 R2 R4 R7 R10 reset state
      chk("R2 reset hsync_n", int'(hsync_n), 1);
      chk("R2 reset vsync_n", int'(vsync_n), 1);
      chk("R4 reset colour", int'({blue, green, red}), 0);
      chk("R7 reset grant", int'(mem_grant), 0);
      chk("R10 reset live_page", int'(live_page), 0);
      rst_n = 1'b1;

      for (int n = 0; n < NCYC; n++) begin
         h = n % HT;
         v = (n / HT) % VT;
         // R7 grant window
         chk("R7 grant", int'(mem_grant), (h >= ((v % 2 != 0) ? FA + 1 : FA + RP + 1)) ? 1 : 0);
         // R9 write enable ownership
         if (!mem_grant) chk("R9 we held", int'(mem_we_n), 1);
         else chk("R9 we passthru", int'(mem_we_n), int'(host_we_n));
         // R8 audio slots
         if (h >= AUD0 && h <= FA) begin
            chk("R8 aud_valid", int'(aud_valid), 1);
            chk("R8 aud_voice", int'(aud_voice), h - AUD0);
            chk("R8 aud addr", int'(mem_addr), int'((h == AUD0) ? VADDR0 : VADDR1));
            chk("R8 aud_data", int'(aud_data), int'(sram((h == AUD0) ? VADDR0 : VADDR1)));
         end else begin
            chk("R8 aud idle", int'(aud_valid), 0);
            if (v % 2 == 0 && v < VA && h > FA && h <= FA + RP) begin
               base = live_m ? P1 : P0;
               chk("R3 fetch addr", int'(mem_addr), base + (v / 2) * RP + (h - FA - 1));
            end else if (h >= ((v % 2 != 0) ? FA + 1 : FA + RP + 1)) begin
               chk("R9 host addr", int'(mem_addr), int'(host_addr));
            end else begin
               chk("R9 blackout addr owner", (mem_addr == host_addr) ? 1 : 0, 0);
            end
         end
         chk("R10 live_page", int'(live_page), int'(live_m));
         if (n >= 1) begin
            hp = (n - 1) % HT;
            vp = ((n - 1) / HT) % VT;
            chk("R1 R2 hsync_n", int'(hsync_n), (hp >= HS) ? 0 : 1);
            chk("R1 R2 vsync_n", int'(vsync_n), (vp >= VSF && vp <= VSL) ? 0 : 1);
            if (vp < VA && hp >= PS && hp < PS + 2 * RP) begin
               base = live_m ? P1 : P0;
               exp_rgb = int'(pal_m[sram(AW'(base + (vp / 2) * RP + (hp - PS) / 2))]);
            end else begin
               exp_rgb = 0;
            end
            chk("R4 R5 R6 colour", int'({blue, green, red}), exp_rgb);
         end
         // R6: write driven last cycle has landed now
         if (pw_pend) pal_m[pw_idx] = 12'(pw_data);
         pw_pend = 1'b0;
         // R10: flip placed early in frame 0 and exactly on the swap edge of frame 1
         nx = n + 1;
         f  = (n == 100) || (n == 747);
         if ((nx % HT) == 0 && ((nx / HT) % VT) == VSF && pend_m) begin
            live_m = !live_m;
            pend_m = f;
         end else begin
            pend_m = pend_m | f;
         end
         flip_req  = f;
         host_we_n = (n % 2) != 0;
         host_addr = 20'h80000 | AW'(n);
         if (n % 7 == 3) begin
            pal_we    = 1'b1;
            pw_idx    = (n * 13) & 255;
            pw_data   = (n * 29) & 12'hFFF;
            pal_idx   = 8'(pw_idx);
            pal_wdata = 12'(pw_data);
            pw_pend   = 1'b1;
         end else begin
            pal_we = 1'b0;
         end
         @(negedge clk);
      end
      chk("R10 final page after two swaps", int'(live_page), 0);
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule